// File: doc/BRIEF.md
# Packed Mixed-Precision Dot-Product Accumulator

This block computes the inner product of one weight row with an activation vector. It serves the matrix-vector step of a fully connected neural-network layer. On every accepted beat it takes four lanes. Each lane pairs an unsigned 8-bit activation with a signed 8-bit weight. The block multiplies the four pairs, adds the four products and adds that beat total into a 32-bit signed running sum. A start flag on the first beat of a row discards the previous sum. A last flag on the final beat closes the row. The closed row is then offered on a valid/ready result port, together with a count of skipped beats and a sticky overflow flag.

A lane is idle when its activation or its weight is zero. An idle lane forms no product. A beat in which all four lanes are idle is a skipped beat: it leaves the sum unchanged and only advances the skip counter. A typical row is 1024 inputs long, which is 256 beats, and a row of that length cannot overflow the sum.

Top module: `pdot_accum`

## Requirements
- R1: Lane k uses bits [8k+7:8k] of both packed words, for k = 0 to 3. The activation byte is unsigned and the weight byte is two's complement. Each accepted beat adds the sum of the four lane products to the running sum.
- R2: A beat accepted with `start` high first clears the running sum, the skip count and the overflow flag, and then applies its own contribution. The finished row therefore reflects only the beats since that start.
- R3: A beat is taken only in a cycle where `in_valid` and `in_ready` are both high. A beat offered while `in_ready` is low changes nothing.
- R4: After a beat with `in_last` is accepted, `res_valid` is high at the next clock edge and `res_sum` shows the final sum. Both hold unchanged until a cycle in which `res_ready` is high.
- R5: `in_ready` is low exactly while a result is pending on the output.
- R6: A beat in which every lane is idle (a zero activation or a zero weight) leaves the running sum unchanged and adds one to `res_skips`.
- R7: `res_skips` saturates at 65535 and does not wrap.
- R8: A sum that leaves the 32-bit signed range wraps in two's complement. `res_ovf` is then set and stays set until the next start beat.
- R9: A 256-beat row in which every activation is 255 and every weight is -128 gives -33423360, with `res_ovf` low.
- R10: After reset, `res_valid` is low, `in_ready` is high, and `res_sum`, `res_skips` and `res_ovf` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Marks the first beat of a row |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat |
| in_last | input | 1 | Marks the final beat of a row |
| in_act | input | 32 | Four packed unsigned activations |
| in_wgt | input | 32 | Four packed signed weights |
| res_valid | output | 1 | Finished row on the output |
| res_ready | input | 1 | Consumer takes the result |
| res_sum | output | 32 | Signed dot product of the row |
| res_skips | output | 16 | Skipped-beat count for the row |
| res_ovf | output | 1 | Sticky overflow flag for the row |

## Verification
The assertions assume that `start` and `in_last` are only meaningful on accepted beats. They also assume that `res_ready` is sampled only while `res_valid` is high. The bench drives every control line from tasks that raise `start` and `in_last` only together with `in_valid`, and drops them again after the accepting edge. It deliberately offers one beat while the output is stalled, to show that such a beat is refused. The long rows used to reach saturation and overflow are streamed back to back, so the sticky and saturating paths are reached through normal traffic and not through forced state.

// File: rtl/pdot_pkg.sv
package pdot_pkg;
  localparam int LANES_DEF = 4;
  localparam int DW_DEF    = 8;
  localparam int ACC_W_DEF = 32;
  localparam int CNT_W_DEF = 16;

  // Signed add overflow: operands agree in sign, result disagrees.
  function automatic logic add_ovf(input logic a_msb, input logic b_msb, input logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction
endpackage

// File: rtl/pdot_lane.sv
module pdot_lane #(
  parameter int DW = 8,
  parameter int PW = 2 * DW + 1
) (
  input  logic                 [DW-1:0] act,
  input  logic                 [DW-1:0] wgt,
  output logic signed          [PW-1:0] prod,
  output logic                          idle
);
  logic signed [PW-1:0] act_x;
  logic signed [PW-1:0] wgt_x;

  assign idle = (act == '0) || (wgt == '0);

  always_comb begin
    act_x = {{(PW-DW){1'b0}}, act};
    wgt_x = {{(PW-DW){wgt[DW-1]}}, wgt};
    if (idle) prod = '0;
    else      prod = act_x * wgt_x;
  end
endmodule

// File: rtl/pdot_tree.sv
module pdot_tree #(
  parameter int LANES = 4,
  parameter int PW    = 17,
  parameter int SW    = PW + $clog2(LANES)
) (
  input  logic signed [PW-1:0] prods [LANES],
  input  logic        [LANES-1:0] idle,
  output logic signed [SW-1:0] sum,
  output logic                 all_idle
);
  always_comb begin
    sum = '0;
    for (int k = 0; k < LANES; k++) sum = sum + SW'(prods[k]);
  end

  assign all_idle = &idle;
endmodule

// File: rtl/pdot_core.sv
module pdot_core
  import pdot_pkg::*;
#(
  parameter int SW    = 19,
  parameter int ACC_W = 32,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    in_valid,
  input  logic                    in_last,
  input  logic signed [SW-1:0]    beat_sum,
  input  logic                    beat_idle,
  input  logic                    res_ready,
  output logic                    in_ready,
  output logic                    res_valid,
  output logic signed [ACC_W-1:0] acc,
  output logic        [CNT_W-1:0] skips,
  output logic                    ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int               MSB     = ACC_W - 1;

  logic                    fire;
  logic signed [ACC_W-1:0] base;
  logic signed [ACC_W-1:0] addend;
  logic signed [ACC_W-1:0] nxt;
  logic                    step_ovf;
  logic        [CNT_W-1:0] skip_base;

  assign in_ready = !res_valid;
  assign fire     = in_valid && in_ready;

  always_comb begin
    base      = start ? '0 : acc;
    skip_base = start ? '0 : skips;
    addend    = ACC_W'(beat_sum);
    nxt       = beat_idle ? base : base + addend;
    step_ovf  = !beat_idle && add_ovf(base[MSB], addend[MSB], nxt[MSB]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      skips     <= '0;
      ovf       <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      if (fire) begin
        acc <= nxt;
        ovf <= (start ? 1'b0 : ovf) | step_ovf;
        if (beat_idle && skip_base != CNT_MAX) skips <= skip_base + 1'b1;
        else                                   skips <= skip_base;
      end
      if (fire && in_last)            res_valid <= 1'b1;
      else if (res_valid && res_ready) res_valid <= 1'b0;
    end
  end

  AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> res_valid); // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(acc))); // R4
  AST_NO_TAKE_WHILE_PENDING: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> ($stable(skips) && $stable(ovf))); // R3
  AST_SKIP_KEEPS_SUM: assert property (@(posedge clk) disable iff (rst)
    (fire && !start && beat_idle) |=> (acc == $past(acc))); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (fire && start && beat_idle) |=> (acc == '0 && skips == 1 && !ovf)); // R2
  AST_SKIP_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (skips == CNT_MAX && !(fire && start)) |=> (skips == CNT_MAX)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !(fire && start)) |=> ovf); // R8
endmodule

// File: rtl/pdot_accum.sv
module pdot_accum
  import pdot_pkg::*;
#(
  parameter int LANES = LANES_DEF,
  parameter int DW    = DW_DEF,
  parameter int ACC_W = ACC_W_DEF,
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_last,
  input  logic [LANES*DW-1:0]   in_act,
  input  logic [LANES*DW-1:0]   in_wgt,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic [ACC_W-1:0]      res_sum,
  output logic [CNT_W-1:0]      res_skips,
  output logic                  res_ovf
);
  localparam int PW = 2 * DW + 1;
  localparam int SW = PW + $clog2(LANES);

  logic signed [PW-1:0]    prods [LANES];
  logic        [LANES-1:0] lane_idle;
  logic signed [SW-1:0]    beat_sum;
  logic                    beat_idle;
  logic signed [ACC_W-1:0] acc;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pdot_lane #(.DW(DW), .PW(PW)) lane_i (
      .act  (in_act[k*DW +: DW]),
      .wgt  (in_wgt[k*DW +: DW]),
      .prod (prods[k]),
      .idle (lane_idle[k])
    );
  end

  pdot_tree #(.LANES(LANES), .PW(PW), .SW(SW)) tree_i (
    .prods    (prods),
    .idle     (lane_idle),
    .sum      (beat_sum),
    .all_idle (beat_idle)
  );

  pdot_core #(.SW(SW), .ACC_W(ACC_W), .CNT_W(CNT_W)) core_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .beat_sum  (beat_sum),
    .beat_idle (beat_idle),
    .res_ready (res_ready),
    .in_ready  (in_ready),
    .res_valid (res_valid),
    .acc       (acc),
    .skips     (res_skips),
    .ovf       (res_ovf)
  );

  assign res_sum = acc;

  AST_READY_FOLLOWS_RESULT: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> !in_ready); // R5
endmodule

// File: tb/pdot_accum_tb.sv
module pdot_accum_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start, in_valid, in_last, res_ready;
  logic [31:0] in_act, in_wgt;
  logic        in_ready, res_valid, res_ovf;
  logic [31:0] res_sum;
  logic [15:0] res_skips;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  int m_acc;
  int m_skip;
  bit m_ovf;

  always #2 clk = ~clk;

  pdot_accum dut_i (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .in_act(in_act), .in_wgt(in_wgt), .res_valid(res_valid),
    .res_ready(res_ready), .res_sum(res_sum), .res_skips(res_skips), .res_ovf(res_ovf)
  );

  // {start, last, act, wgt}
  localparam logic [65:0] VEC [12] = '{
    {1'b1, 1'b0, 32'h01020304, 32'h01010101},
    {1'b0, 1'b1, 32'h0A0B0C0D, 32'hFF02FE03},
    {1'b1, 1'b1, 32'hFFFFFFFF, 32'h80808080},
    {1'b1, 1'b0, 32'h00000000, 32'h7F7F7F7F},
    {1'b0, 1'b1, 32'h12340000, 32'h0000ABCD},
    {1'b1, 1'b0, 32'h80FF7F01, 32'h7F80FF01},
    {1'b0, 1'b1, 32'h00010000, 32'h00FF0000},
    {1'b1, 1'b1, 32'h00000001, 32'h000000FF},
    {1'b1, 1'b0, 32'hC8C8C8C8, 32'h9C9C9C9C},
    {1'b0, 1'b0, 32'h00000000, 32'h00000000},
    {1'b0, 1'b1, 32'h01010101, 32'h64646464},
    {1'b1, 1'b1, 32'h00000000, 32'h00000000}
  };

  task automatic check(input string req, input longint got, input longint exp);
    n_cmp++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic model_step(input bit st, input logic [31:0] a, input logic [31:0] w);
    longint s;
    int     bv = 0;
    bit     sk = 1'b1;
    if (st) begin m_acc = 0; m_skip = 0; m_ovf = 1'b0; end
    for (int k = 0; k < 4; k++) begin
      int pa = int'(a[8*k +: 8]);
      int pw = int'($signed(w[8*k +: 8]));
      if (pa != 0 && pw != 0) begin sk = 1'b0; bv += pa * pw; end
    end
    s = longint'(m_acc) + longint'(bv);
    if (s > 64'sd2147483647 || s < -64'sd2147483648) m_ovf = 1'b1;
    m_acc = int'(s[31:0]);
    if (sk && m_skip < 65535) m_skip++;
  endtask

  task automatic send_beat(input bit st, input bit lst, input logic [31:0] a, input logic [31:0] w);
    @(negedge clk);
    start = st; in_last = lst; in_act = a; in_wgt = w; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    model_step(st, a, w);
    @(posedge clk);
    #1;
    in_valid = 1'b0; start = 1'b0; in_last = 1'b0;
  endtask

  task automatic take_result(input string req);
    @(negedge clk);
    check({req, " R4 res_valid one cycle after last"}, longint'(res_valid), 1);
    check({req, " R5 in_ready low while pending"}, longint'(in_ready), 0);
    check({req, " sum"}, longint'($signed(res_sum)), longint'(m_acc));
    check({req, " R6 skips"}, longint'(res_skips), longint'(m_skip));
    check({req, " R8 ovf"}, longint'(res_ovf), longint'(m_ovf));
    res_ready = 1'b1;
    @(posedge clk);
    #1;
    res_ready = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; in_valid = 1'b0; in_last = 1'b0; res_ready = 1'b0;
    in_act = '0; in_wgt = '0;
    m_acc = 0; m_skip = 0; m_ovf = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R10 reset res_valid", longint'(res_valid), 0);
    check("R10 reset in_ready", longint'(in_ready), 1);
    check("R10 reset sum", longint'(res_sum), 0);
    check("R10 reset skips", longint'(res_skips), 0);
    check("R10 reset ovf", longint'(res_ovf), 0);

    // Table: R1 lane math, R2 start clearing, R6 skipped beats
    for (int i = 0; i < 12; i++) begin
      send_beat(VEC[i][65], VEC[i][64], VEC[i][63:32], VEC[i][31:0]);
      if (VEC[i][64]) take_result("R1 R2 table row");
    end

    // One-beat extreme row: 4*255*-128
    send_beat(1'b1, 1'b1, 32'hFFFFFFFF, 32'h80808080);
    take_result("R1 extreme single beat");
    check("R1 extreme literal", longint'($signed(res_sum)), -130560);

    // Random rows against the model
    for (int r = 0; r < 8; r++) begin
      int len = 1 + int'($urandom_range(0, 19));
      for (int b = 0; b < len; b++) begin
        logic [31:0] a = $urandom();
        logic [31:0] w = $urandom();
        if ($urandom_range(0, 3) == 0) a[15:0] = '0;
        if ($urandom_range(0, 3) == 0) w[31:16] = '0;
        if ($urandom_range(0, 7) == 0) a = '0;
        send_beat(b == 0, b == len - 1, a, w);
      end
      take_result("R1 random row");
    end

    // R3/R5: beat offered during a stalled result is refused
    send_beat(1'b1, 1'b1, 32'h02020202, 32'h03030303);
    @(negedge clk);
    start = 1'b1; in_last = 1'b1; in_act = 32'h01010101; in_wgt = 32'h01010101; in_valid = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R5 in_ready low while stalled", longint'(in_ready), 0);
      check("R3 sum held during stall", longint'($signed(res_sum)), 24);
    end
    in_valid = 1'b0; start = 1'b0; in_last = 1'b0;
    take_result("R3 stalled row");
    send_beat(1'b0, 1'b1, 32'h00000001, 32'h00000001);
    take_result("R3 refused beat not counted");
    check("R3 continued sum", longint'($signed(res_sum)), 25);

    // R9: full 256-beat extreme row
    for (int b = 0; b < 256; b++) send_beat(b == 0, b == 255, 32'hFFFFFFFF, 32'h80808080);
    take_result("R9 full row");
    check("R9 full row literal", longint'($signed(res_sum)), -33423360);
    check("R9 no overflow", longint'(res_ovf), 0);

    // R7: saturating skip counter
    for (int b = 0; b < 65540; b++) send_beat(b == 0, b == 65539, 32'h00000000, 32'h55555555);
    take_result("R7 saturation row");
    check("R7 skips saturate", longint'(res_skips), 65535);
    send_beat(1'b1, 1'b1, 32'h00000000, 32'h00000000);
    take_result("R2 start clears skips");
    check("R2 skips after start", longint'(res_skips), 1);

    // R8: wrap and sticky overflow
    for (int b = 0; b < 16579; b++) send_beat(b == 0, b == 16578, 32'hFFFFFFFF, 32'h7F7F7F7F);
    take_result("R8 overflow row");
    check("R8 ovf set", longint'(res_ovf), 1);
    send_beat(1'b0, 1'b1, 32'h00000000, 32'h00000000);
    take_result("R8 ovf sticky");
    check("R8 ovf still set", longint'(res_ovf), 1);
    send_beat(1'b1, 1'b1, 32'h00000003, 32'h00000002);
    take_result("R8 start clears ovf");
    check("R8 ovf cleared", longint'(res_ovf), 0);
    check("R2 sum after start", longint'($signed(res_sum)), 6);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule